// File: doc/BRIEF.md
# Configurable Phase-Frequency Detector with Lock Flag

This block compares a reference clock against a divided oscillator signal, both sampled on a fast system clock. It reports the phase or frequency error in one of two output forms. The first is a pair of active-low pulse lines. The second is a single three-state pump command (source, sink or float), given as a pump-enable line plus a direction line. A polarity input swaps the up and down roles. This suits loops where a higher control voltage lowers the oscillator frequency.

When both inputs have produced an edge, the detector holds that state for a programmable number of clocks before it returns to neutral. Matched inputs therefore still give a short coincident pulse on both lines, so the detector has no dead zone. A lock flag combines the two active-low lines with an AND. A standby input parks every output at its rest level and holds the detector neutral. A two-bit pump-strength code passes through a register to the analog side.

The block has no data stream, so every pin is a plain level-sensitive control or status line.

Top module: `pfd_lock_top`

## Requirements
- R1: After reset `r_out_n`, `v_out_n` and `lock_n` are 1, `pump_en` and `pump_dir` are 0 and `gain_code` is 00.
- R2: With `mode_dbl`=1 and `polarity`=0, a reference rising edge that arrives d clocks before the oscillator edge drives `r_out_n` low for d+RST_CYC clocks and `v_out_n` low for RST_CYC clocks. An oscillator edge that arrives d clocks first drives `v_out_n` low for d+RST_CYC clocks and `r_out_n` low for RST_CYC clocks. Both lines return high on the same clock.
- R3: With `polarity`=1 the roles of `r_out_n` and `v_out_n` in R2 are exchanged.
- R4: Rising edges on both inputs on the same clock drive both lines low together for exactly RST_CYC clocks (default 2).
- R5: With `mode_dbl`=0, `r_out_n` and `v_out_n` stay 1, and `pump_en` is 1 for exactly d clocks. During that time `pump_dir` is 1 (source) when the reference edge came first and 0 (sink) when the oscillator edge came first, and `polarity`=1 inverts `pump_dir`. Matched edges leave `pump_en` at 0. With `mode_dbl`=1, `pump_en` stays 0.
- R6: Outside standby, `lock_n` is 0 whenever either internal up/down flag is set. It therefore gives one low pulse of d+RST_CYC clocks per comparison in either output mode.
- R7: While `standby`=1, input edges have no effect. `r_out_n`, `v_out_n` and `lock_n` stay 1 and `pump_en` stays 0.
- R8: The detector flags are clear while in standby, so the first comparison after `standby` falls behaves as if no earlier edge had arrived.
- R9: `gain_code` equals the `gain_sel` value of the previous clock. The codes are 00 = 5 %, 01 = 50 %, 10 = 80 % and 11 = 100 % pump strength.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference frequency input, asynchronous |
| vco_in | input | 1 | Divided oscillator input, asynchronous |
| standby | input | 1 | 1 parks all outputs at rest and clears the detector |
| mode_dbl | input | 1 | 1 = active-low pulse pair, 0 = three-state pump command |
| polarity | input | 1 | 1 swaps the up and down roles |
| gain_sel | input | 2 | Requested pump strength code |
| r_out_n | output | 1 | Active-low pulse line, reference-leads side at polarity 0 |
| v_out_n | output | 1 | Active-low pulse line, oscillator-leads side at polarity 0 |
| pump_en | output | 1 | 1 = pump drives, 0 = float |
| pump_dir | output | 1 | 1 = source, 0 = sink, valid while pump_en is 1 |
| lock_n | output | 1 | AND of the two active-low lines |
| gain_code | output | 2 | Registered pump strength code |

## Verification
The assertions assume that each input level lasts at least three system clocks, so the synchronizer sees every edge exactly once. They also assume that `mode_dbl` and `polarity` change only while the detector is neutral. The stimulus holds each input high for six clocks and low for at least twelve. It changes the configuration only between comparisons, after the idle gap. A scoreboard predicts every pulse width from the edge spacing, the mode and the polarity. Each predicted pulse is matched against the measured low run of `lock_n` and the runs that share it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int GAIN_W = 2;

  typedef enum logic [GAIN_W-1:0] {
    STRENGTH_5   = 2'b00,
    STRENGTH_50  = 2'b01,
    STRENGTH_80  = 2'b10,
    STRENGTH_100 = 2'b11
  } strength_e;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2
endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core #(
  parameter int RST_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               standby,
  input  logic               ref_rise,
  input  logic               vco_rise,
  output pfd_pkg::pfd_flags_t flags
);
  localparam int CNT_W = (RST_CYC < 2) ? 1 : $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             both;
  logic             clr;

  assign both = flags.up & flags.dn;
  assign clr  = both & (hold_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      flags    <= '0;
      hold_cnt <= '0;
    end else begin
      flags.up <= ref_rise | (flags.up & ~clr);
      flags.dn <= vco_rise | (flags.dn & ~clr);
      hold_cnt <= (both && !clr) ? hold_cnt + 1'b1 : '0;
    end
  end

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (both && hold_cnt == LAST && !ref_rise && !vco_rise && !standby)
      |=> (!flags.up && !flags.dn)); // R4
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= LAST); // R4
  AST_STBY_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!flags.up && !flags.dn)); // R8
endmodule

// File: rtl/pfd_out_steer.sv
module pfd_out_steer
  import pfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              mode_dbl,
  input  logic              polarity,
  input  pfd_flags_t        flags,
  input  logic [GAIN_W-1:0] gain_sel,
  output logic              r_out_n,
  output logic              v_out_n,
  output logic              pump_en,
  output logic              pump_dir,
  output logic              lock_n,
  output logic [GAIN_W-1:0] gain_code
);
  logic r_act, v_act, one_side, lock_nx;

  always_comb begin
    r_act    = polarity ? flags.dn : flags.up;
    v_act    = polarity ? flags.up : flags.dn;
    one_side = flags.up ^ flags.dn;
    lock_nx  = ~(flags.up | flags.dn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_out_n   <= 1'b1;
      v_out_n   <= 1'b1;
      pump_en   <= 1'b0;
      pump_dir  <= 1'b0;
      lock_n    <= 1'b1;
      gain_code <= STRENGTH_5;
    end else begin
      gain_code <= gain_sel;
      if (standby) begin
        r_out_n  <= 1'b1;
        v_out_n  <= 1'b1;
        pump_en  <= 1'b0;
        pump_dir <= 1'b0;
        lock_n   <= 1'b1;
      end else begin
        lock_n   <= lock_nx;
        r_out_n  <= ~(mode_dbl & r_act);
        v_out_n  <= ~(mode_dbl & v_act);
        pump_en  <= ~mode_dbl & one_side;
        pump_dir <= ~mode_dbl & one_side & (flags.up ^ polarity);
      end
    end
  end

  AST_STBY_REST: assert property (@(posedge clk) disable iff (rst)
    standby |=> (r_out_n && v_out_n && !pump_en && lock_n)); // R7
  AST_SINGLE_PAIR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !mode_dbl |=> (r_out_n && v_out_n)); // R5
  AST_DOUBLE_NO_PUMP: assert property (@(posedge clk) disable iff (rst)
    mode_dbl |=> !pump_en); // R5
  AST_LOCK_AND: assert property (@(posedge clk) disable iff (rst)
    (!r_out_n || !v_out_n) |-> !lock_n); // R6
  AST_GAIN_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> gain_code == $past(gain_sel)); // R9
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              vco_in,
  input  logic              standby,
  input  logic              mode_dbl,
  input  logic              polarity,
  input  logic [GAIN_W-1:0] gain_sel,
  output logic              r_out_n,
  output logic              v_out_n,
  output logic              pump_en,
  output logic              pump_dir,
  output logic              lock_n,
  output logic [GAIN_W-1:0] gain_code
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] rise;
  pfd_flags_t     flags;

  assign raw_in = {vco_in, ref_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[ch]),
      .rise (rise[ch])
    );
  end

  pfd_flag_core #(.RST_CYC(RST_CYC)) u_core (
    .clk      (clk),
    .rst      (rst),
    .standby  (standby),
    .ref_rise (rise[0]),
    .vco_rise (rise[1]),
    .flags    (flags)
  );

  pfd_out_steer u_steer (
    .clk       (clk),
    .rst       (rst),
    .standby   (standby),
    .mode_dbl  (mode_dbl),
    .polarity  (polarity),
    .flags     (flags),
    .gain_sel  (gain_sel),
    .r_out_n   (r_out_n),
    .v_out_n   (v_out_n),
    .pump_en   (pump_en),
    .pump_dir  (pump_dir),
    .lock_n    (lock_n),
    .gain_code (gain_code)
  );
endmodule

// File: tb/pfd_lock_top_test.sv
`timescale 1ns/1ps
module pfd_lock_top_test;
  localparam int RST_CYC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, vco_in = 1'b0, standby = 1'b0;
  logic mode_dbl = 1'b1, polarity = 1'b0;
  logic [1:0] gain_sel = 2'b00;
  logic r_out_n, v_out_n, pump_en, pump_dir, lock_n;
  logic [1:0] gain_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int    r_w;
    int    v_w;
    int    l_w;
    int    pe_w;
    int    dir;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pfd_lock_top #(.SYNC_STAGES(2), .RST_CYC(RST_CYC)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .vco_in(vco_in),
    .standby(standby), .mode_dbl(mode_dbl), .polarity(polarity),
    .gain_sel(gain_sel), .r_out_n(r_out_n), .v_out_n(v_out_n),
    .pump_en(pump_en), .pump_dir(pump_dir), .lock_n(lock_n),
    .gain_code(gain_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: predicts the pulse set of one comparison, then applies the edges.
  task automatic pair(input bit ref_first, input int d, input string req);
    exp_t e;
    int up_w, dn_w;
    up_w = ref_first ? d + RST_CYC : RST_CYC;
    dn_w = ref_first ? RST_CYC : d + RST_CYC;
    e.req = req;
    e.l_w = d + RST_CYC;
    if (mode_dbl) begin
      e.r_w  = polarity ? dn_w : up_w;
      e.v_w  = polarity ? up_w : dn_w;
      e.pe_w = 0;
      e.dir  = -1;
    end else begin
      e.r_w  = 0;
      e.v_w  = 0;
      e.pe_w = d;
      e.dir  = (d == 0) ? -1 : int'(ref_first ^ polarity);
    end
    sb.push_back(e);
    @(negedge clk);
    if (d == 0) begin
      ref_in = 1'b1; vco_in = 1'b1;
    end else begin
      if (ref_first) ref_in = 1'b1; else vco_in = 1'b1;
      repeat (d) @(negedge clk);
      if (ref_first) vco_in = 1'b1; else ref_in = 1'b1;
    end
    repeat (6) @(negedge clk);
    ref_in = 1'b0; vco_in = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // Monitor: measures low runs and pump runs, compares when lock_n recovers.
  int cnt_r = 0, cnt_v = 0, cnt_l = 0, cnt_pe = 0, last_dir = -1;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (!r_out_n) cnt_r++;
      if (!v_out_n) cnt_v++;
      if (pump_en) begin cnt_pe++; last_dir = int'(pump_dir); end
      if (!lock_n) cnt_l++;
      else if (cnt_l > 0) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected lock pulse width", cnt_l, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cnt_r == e.r_w, e.req, "r_out_n low width", cnt_r, e.r_w);
          chk(cnt_v == e.v_w, e.req, "v_out_n low width", cnt_v, e.v_w);
          chk(cnt_l == e.l_w, "R6", "lock_n low width", cnt_l, e.l_w);
          chk(cnt_pe == e.pe_w, "R5", "pump_en width", cnt_pe, e.pe_w);
          if (e.dir >= 0)
            chk(last_dir == e.dir, "R5", "pump_dir", last_dir, e.dir);
        end
        cnt_r = 0; cnt_v = 0; cnt_l = 0; cnt_pe = 0; last_dir = -1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(r_out_n == 1'b1, "R1", "r_out_n", int'(r_out_n), 1);
    chk(v_out_n == 1'b1, "R1", "v_out_n", int'(v_out_n), 1);
    chk(lock_n == 1'b1, "R1", "lock_n", int'(lock_n), 1);
    chk(pump_en == 1'b0, "R1", "pump_en", int'(pump_en), 0);
    chk(pump_dir == 1'b0, "R1", "pump_dir", int'(pump_dir), 0);
    chk(gain_code == 2'b00, "R1", "gain_code", int'(gain_code), 0);

    // R2, R4 double-ended, polarity 0
    pair(1'b1, 3, "R2");
    pair(1'b0, 5, "R2");
    pair(1'b1, 0, "R4");
    pair(1'b0, 1, "R2");
    // R3 polarity swap
    polarity = 1'b1;
    pair(1'b1, 4, "R3");
    pair(1'b0, 2, "R3");
    pair(1'b1, 0, "R4");
    // R5 single-ended three-state
    mode_dbl = 1'b0; polarity = 1'b0;
    pair(1'b1, 3, "R5");
    pair(1'b0, 4, "R5");
    pair(1'b1, 0, "R5");
    polarity = 1'b1;
    pair(1'b1, 2, "R5");
    pair(1'b0, 3, "R5");
    mode_dbl = 1'b1; polarity = 1'b0;
    repeat (4) @(negedge clk);

    // R7 standby ignores edges and parks outputs
    standby = 1'b1;
    repeat (2) @(negedge clk);
    bad = 0;
    ref_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!r_out_n || !v_out_n || pump_en || !lock_n) bad++;
    end
    vco_in = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!r_out_n || !v_out_n || pump_en || !lock_n) bad++;
    end
    chk(bad == 0, "R7", "cycles off rest in standby", bad, 0);
    ref_in = 1'b0; vco_in = 1'b0;
    repeat (6) @(negedge clk);
    standby = 1'b0;
    repeat (6) @(negedge clk);

    // R8 edge just before standby must not survive standby
    ref_in = 1'b1;
    @(negedge clk);
    standby = 1'b1;
    repeat (4) @(negedge clk);
    ref_in = 1'b0;
    repeat (4) @(negedge clk);
    standby = 1'b0;
    repeat (4) @(negedge clk);
    pair(1'b1, 0, "R8");

    // R9 gain pass-through: 00=5%, 01=50%, 10=80%, 11=100%
    for (int g = 3; g >= 0; g--) begin
      gain_sel = 2'(g);
      @(negedge clk);
      chk(gain_code == 2'(g), "R9", "gain_code", int'(gain_code), g);
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2", "pending predicted pulses", sb.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule